// File: doc/BRIEF.md
# Two-Wire Register Target with Page Writes

This block is a two-wire serial target that runs on a fast system clock. It lets an external host read and write a 256-entry byte register space. SCL and SDA are oversampled and synchronized. Start and Stop events are found on the synchronized lines. The SDA line is pulled low through a single output-enable. The block itself holds no storage. A write port and a combinational read port connect it to a register file outside the block.

Each transaction opens with an address byte. Its upper four bits must equal a programmable type code, the next three bits must equal three strapped pins, and the last bit selects the direction. In a write, the first byte after the address sets an internal pointer. The data bytes that follow are stored at successive locations inside the pointer's 16-byte page. When a Stop ends a transaction that stored at least one byte, a one-cycle commit pulse goes to the nonvolatile store.

Reads start at the pointer. A host usually sets the pointer with a write that carries no data and is followed by a repeated Start. The pointer steps forward after every byte the host acknowledges.

Top module: `i2c_page_target`

## Requirements
- R1: SDA is sampled on the rising edge of SCL. Data bytes go out most significant bit first. `sda_oe` changes only while SCL is low.
- R2: A falling SDA while SCL is high is a Start and a rising SDA while SCL is high is a Stop. A Start in any state drops any partly shifted byte and restarts address reception.
- R3: An address byte matches when bits [7:4] equal `dev_type` and bits [3:1] equal `addr_pins`. Bit 0 selects the direction: 1 is read, 0 is write. On a match, `sda_oe` is high for the whole ninth clock.
- R4: After an address mismatch the block never asserts `sda_oe` and never pulses `wr_en` until the next Start.
- R5: In a write, the first byte after the address loads the pointer. Each later byte gives one `wr_en` pulse, with `wr_addr` equal to the pointer and `wr_data` equal to the byte, and the byte is acknowledged.
- R6: After each stored byte the low four pointer bits increase modulo 16 and the upper four bits stay fixed. A 17th byte therefore overwrites the first location written.
- R7: A Stop pulses `commit` for exactly one cycle when a data byte has been stored since the previous Stop, including across repeated Starts. A Stop after only a pointer byte gives no pulse.
- R8: A read sends the byte at the pointer first. After each host acknowledge it sends the byte at the pointer plus one, which wraps over all 8 bits. The pointer is kept between transactions.
- R9: A host NACK (SDA high in the acknowledge slot) ends the read. `sda_oe` then stays low through further clocks until a Start.
- R10: During reset and immediately after it, `sda_oe`, `wr_en` and `commit` are 0 and `rd_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| dev_type | input | 4 | Programmable type code matched against address bits [7:4] |
| addr_pins | input | 3 | Strapped bus address matched against address bits [3:1] |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_addr | output | 8 | Register write address |
| wr_data | output | 8 | Register write data |
| rd_addr | output | 8 | Register read address (the pointer) |
| rd_data | input | 8 | Register read data for `rd_addr` |
| commit | output | 1 | One-cycle nonvolatile commit strobe at Stop |

## Verification
A bus event (Start or Stop) and a byte-level action can be due on the same SCL cycle. In that case the event wins: it must cancel the byte being shifted and must not produce a stray write or acknowledge. The bench provokes this by issuing a repeated Start after only four bits of a data byte. It then checks that the write count rises only by the byte of the new transaction, and that the location under the abandoned byte still reads back its old value. A second overlap is a Stop that closes a transaction which stored data before a repeated Start. The bench checks that this produces exactly one commit pulse, one cycle wide.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK
    } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_last;
        logic              sda_last;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.scl_sh   = {q.scl_sh[STAGES-2:0], scl_i};
        d.sda_sh   = {q.sda_sh[STAGES-2:0], sda_i};
        d.scl_last = q.scl_sh[STAGES-1];
        d.sda_last = q.sda_sh[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end

    assign scl_s     = q.scl_sh[STAGES-1];
    assign sda_s     = q.sda_sh[STAGES-1];
    assign scl_rise  = scl_s & ~q.scl_last;
    assign scl_fall  = ~scl_s & q.scl_last;
    assign start_det = scl_s & q.scl_last & q.sda_last & ~sda_s;
    assign stop_det  = scl_s & q.scl_last & ~q.sda_last & sda_s;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter int AW        = 8,
    parameter int DW        = 8,
    parameter int PAGE_BITS = 4,
    parameter int TYPE_W    = 4,
    parameter int PIN_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [TYPE_W-1:0] dev_type,
    input  logic [PIN_W-1:0]  addr_pins,
    input  logic [DW-1:0]     rd_data,
    output logic              sda_oe,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic [AW-1:0]     rd_addr,
    output logic              commit
);
    localparam int CNT_W = $clog2(DW + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DW);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DW - 1);

    typedef struct packed {
        tgt_state_e       state;
        tgt_state_e       after;
        logic [CNT_W-1:0] cnt;
        logic [DW-1:0]    shreg;
        logic [DW-1:0]    txreg;
        logic [AW-1:0]    ptr;
        logic             pending;
        logic             host_ack;
        logic             sda_oe;
        logic             wr_en;
        logic [AW-1:0]    wr_addr;
        logic [DW-1:0]    wr_data;
        logic             commit;
    } eng_t;

    eng_t q, d;
    logic addr_match;

    assign addr_match = (q.shreg[DW-1 -: TYPE_W] == dev_type) &&
                        (q.shreg[DW-1-TYPE_W -: PIN_W] == addr_pins);

    always_comb begin
        d        = q;
        d.wr_en  = 1'b0;
        d.commit = 1'b0;
        if (stop_det) begin
            d.state   = ST_IDLE;
            d.sda_oe  = 1'b0;
            d.cnt     = '0;
            d.commit  = q.pending;
            d.pending = 1'b0;
        end else if (start_det) begin
            d.state  = ST_ADDR;
            d.sda_oe = 1'b0;
            d.cnt    = '0;
        end else begin
            case (q.state)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise && q.cnt != CNT_FULL) begin
                        d.shreg = {q.shreg[DW-2:0], sda_s};
                        d.cnt   = q.cnt + CNT_W'(1);
                    end else if (scl_fall && q.cnt == CNT_FULL) begin
                        d.cnt    = '0;
                        d.state  = ST_ACK;
                        d.sda_oe = 1'b1;
                        case (q.state)
                            ST_ADDR: begin
                                if (!addr_match) begin
                                    d.state  = ST_IDLE;
                                    d.sda_oe = 1'b0;
                                end else if (q.shreg[0]) begin
                                    d.txreg = rd_data;
                                    d.ptr   = q.ptr + AW'(1);
                                    d.after = ST_RDATA;
                                end else begin
                                    d.after = ST_PTR;
                                end
                            end
                            ST_PTR: begin
                                d.ptr   = q.shreg[AW-1:0];
                                d.after = ST_WDATA;
                            end
                            default: begin
                                d.wr_en   = 1'b1;
                                d.wr_addr = q.ptr;
                                d.wr_data = q.shreg;
                                d.ptr     = {q.ptr[AW-1:PAGE_BITS],
                                             q.ptr[PAGE_BITS-1:0] + PAGE_BITS'(1)};
                                d.pending = 1'b1;
                                d.after   = ST_WDATA;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.state  = q.after;
                        d.cnt    = '0;
                        d.sda_oe = (q.after == ST_RDATA) ? ~q.txreg[DW-1] : 1'b0;
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (q.cnt == CNT_LAST) begin
                            d.state  = ST_RACK;
                            d.sda_oe = 1'b0;
                            d.cnt    = '0;
                        end else begin
                            d.txreg  = {q.txreg[DW-2:0], 1'b0};
                            d.sda_oe = ~q.txreg[DW-2];
                            d.cnt    = q.cnt + CNT_W'(1);
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        d.host_ack = ~sda_s;
                    end else if (scl_fall) begin
                        if (q.host_ack) begin
                            d.txreg  = rd_data;
                            d.ptr    = q.ptr + AW'(1);
                            d.state  = ST_RDATA;
                            d.sda_oe = ~rd_data[DW-1];
                        end else begin
                            d.state  = ST_IDLE;
                            d.sda_oe = 1'b0;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.after <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe  = q.sda_oe;
    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;
    assign rd_addr = q.ptr;
    assign commit  = q.commit;

    // R1
    sda_oe_lowscl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_s);
    // R7
    commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(stop_det));
    // R7
    commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);
    // R4
    idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q.state == ST_IDLE) |-> !sda_oe);
    // R5
    write_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> sda_oe);
endmodule

// File: rtl/i2c_page_target.sv
module i2c_page_target #(
    parameter int AW          = 8,
    parameter int DW          = 8,
    parameter int PAGE_BITS   = 4,
    parameter int TYPE_W      = 4,
    parameter int PIN_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [TYPE_W-1:0] dev_type,
    input  logic [PIN_W-1:0]  addr_pins,
    output logic              wr_en,
    output logic [AW-1:0]     wr_addr,
    output logic [DW-1:0]     wr_data,
    output logic [AW-1:0]     rd_addr,
    input  logic [DW-1:0]     rd_data,
    output logic              commit
);
    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_tgt_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_tgt_engine #(
        .AW(AW), .DW(DW), .PAGE_BITS(PAGE_BITS), .TYPE_W(TYPE_W), .PIN_W(PIN_W)
    ) engine_i (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .dev_type(dev_type), .addr_pins(addr_pins), .rd_data(rd_data),
        .sda_oe(sda_oe), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .commit(commit)
    );
endmodule

// File: tb/i2c_page_target_tb_top.sv
module i2c_page_target_tb_top;
    localparam int Q = 20;
    localparam int H = 40;
    localparam logic [3:0] TYPE = 4'hA;
    localparam logic [2:0] PINS = 3'b101;
    localparam logic [7:0] ADDR_W = {TYPE, PINS, 1'b0};
    localparam logic [7:0] ADDR_R = {TYPE, PINS, 1'b1};
    // vector: pointer, byte count, first data value
    localparam logic [23:0] VECS [0:3] = '{24'h10_01_A0, 24'h3C_06_11,
                                           24'h70_12_C0, 24'hFE_03_00};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_h = 1'b1;
    logic sda_bus;
    logic sda_oe, wr_en, commit;
    logic [7:0] wr_addr, wr_data, rd_addr, rd_data;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    int nchk = 0, nerr = 0;
    int wr_cnt = 0, commit_cyc = 0, commit_evt = 0, viol = 0;
    logic commit_prev = 1'b0, oe_prev = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;
    assign sda_bus = sda_h & ~sda_oe;
    assign rd_data = mem[rd_addr];

    i2c_page_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus), .sda_oe(sda_oe),
        .dev_type(TYPE), .addr_pins(PINS), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .commit(commit)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 256; i++) mem[i] <= 8'(i) ^ 8'h5A;
        end else begin
            if (wr_en) begin
                mem[wr_addr] <= wr_data;
                wr_cnt <= wr_cnt + 1;
            end
            if (commit) commit_cyc <= commit_cyc + 1;
            if (commit && !commit_prev) commit_evt <= commit_evt + 1;
            if (scl && sda_oe != oe_prev) viol <= viol + 1;
            commit_prev <= commit;
            oe_prev <= sda_oe;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b, output logic r);
        wclk(Q); sda_h = b; wclk(Q); scl = 1'b1; wclk(H); r = sda_bus; scl = 1'b0;
    endtask

    task automatic bus_start();
        sda_h = 1'b1; wclk(Q); scl = 1'b1; wclk(Q); sda_h = 1'b0; wclk(Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; wclk(Q); scl = 1'b1; wclk(Q); sda_h = 1'b1; wclk(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) put_bit(b[i], r);
        put_bit(1'b1, r);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic hack, output logic [7:0] b);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            put_bit(1'b1, r);
            b[i] = r;
        end
        put_bit(~hack, r);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        logic a, allack, r;
        logic [7:0] b;
        int w0, c0;
        for (int i = 0; i < 256; i++) exp_mem[i] = 8'(i) ^ 8'h5A;
        wclk(4);
        // R10 during reset
        chk("R10 sda_oe in reset", int'(sda_oe), 0);
        chk("R10 wr_en in reset", int'(wr_en), 0);
        wclk(2); rst_n = 1'b1; wclk(3);
        chk("R10 sda_oe after reset", int'(sda_oe), 0);
        chk("R10 commit after reset", int'(commit), 0);
        chk("R10 pointer after reset", int'(rd_addr), 0);

        // table of page writes followed by read-back (R3 R5 R6 R7 R8)
        for (int v = 0; v < 4; v++) begin
            logic [7:0] p, n, s, pa;
            int nrd;
            p = VECS[v][23:16]; n = VECS[v][15:8]; s = VECS[v][7:0];
            w0 = wr_cnt; c0 = commit_evt; allack = 1'b1;
            bus_start();
            send_byte(ADDR_W, a); chk("R3 address ack", int'(a), 1);
            send_byte(p, a); allack &= a;
            for (int k = 0; k < int'(n); k++) begin
                send_byte(s + 8'(k), a); allack &= a;
                // R6 wrap inside the page
                pa = {p[7:4], p[3:0] + 4'(k)};
                exp_mem[pa] = s + 8'(k);
            end
            bus_stop(); wclk(4);
            chk("R5 bytes acknowledged", int'(allack), 1);
            chk("R5 write strobes", wr_cnt - w0, int'(n));
            chk("R7 one commit per write", commit_evt - c0, 1);
            nrd = (int'(n) > 16) ? 16 : int'(n);
            bus_start(); send_byte(ADDR_W, a); send_byte(p, a);
            bus_start(); send_byte(ADDR_R, a);
            for (int k = 0; k < nrd; k++) begin
                recv_byte(k != nrd - 1, b);
                chk("R8 R6 read data", int'(b), int'(exp_mem[8'(p + 8'(k))]));
            end
            bus_stop();
        end

        // R4 type-code mismatch: no ack, no writes, no commit
        w0 = wr_cnt; c0 = commit_evt;
        bus_start(); send_byte({4'h3, PINS, 1'b0}, a);
        chk("R4 no ack on type mismatch", int'(a), 0);
        send_byte(8'h20, a); r = a; send_byte(8'h77, a);
        chk("R4 later bytes ignored", int'(r | a), 0);
        bus_stop(); wclk(4);
        chk("R4 no write after mismatch", wr_cnt - w0, 0);
        chk("R4 no commit after mismatch", commit_evt - c0, 0);

        // R3 pin mismatch
        bus_start(); send_byte({TYPE, 3'b100, 1'b0}, a);
        chk("R3 no ack on pin mismatch", int'(a), 0);
        bus_stop();

        // R7 pointer-only write then Stop; R8 pointer kept across transactions
        c0 = commit_evt;
        bus_start(); send_byte(ADDR_W, a); send_byte(8'h35, a); bus_stop(); wclk(4);
        chk("R7 no commit for pointer only", commit_evt - c0, 0);
        bus_start(); send_byte(ADDR_R, a); recv_byte(1'b0, b); bus_stop();
        chk("R8 read from kept pointer", int'(b), int'(exp_mem[8'h35]));

        // R2 Start in the middle of a data byte aborts it
        w0 = wr_cnt; c0 = commit_evt;
        bus_start(); send_byte(ADDR_W, a); send_byte(8'h40, a);
        for (int i = 0; i < 4; i++) put_bit(1'b1, r);
        bus_start(); send_byte(ADDR_W, a); send_byte(8'h44, a);
        send_byte(8'h99, a); exp_mem[8'h44] = 8'h99;
        bus_stop(); wclk(4);
        chk("R2 only new byte written", wr_cnt - w0, 1);
        chk("R7 commit after aborted byte", commit_evt - c0, 1);
        bus_start(); send_byte(ADDR_W, a); send_byte(8'h40, a);
        bus_start(); send_byte(ADDR_R, a); recv_byte(1'b0, b); bus_stop();
        chk("R2 aborted location unchanged", int'(b), int'(exp_mem[8'h40]));

        // R7 data write, repeated Start, read, Stop: one commit
        c0 = commit_evt;
        bus_start(); send_byte(ADDR_W, a); send_byte(8'h20, a);
        send_byte(8'h11, a); exp_mem[8'h20] = 8'h11;
        bus_start(); send_byte(ADDR_R, a); recv_byte(1'b0, b);
        bus_stop(); wclk(4);
        chk("R8 read after page write", int'(b), int'(exp_mem[8'h21]));
        chk("R7 commit kept across repeated start", commit_evt - c0, 1);

        // R9 NACK ends the read
        bus_start(); send_byte(ADDR_W, a); send_byte(8'h70, a);
        bus_start(); send_byte(ADDR_R, a);
        recv_byte(1'b1, b); chk("R8 first of two", int'(b), int'(exp_mem[8'h70]));
        recv_byte(1'b0, b); chk("R8 second of two", int'(b), int'(exp_mem[8'h71]));
        allack = 1'b1;
        for (int i = 0; i < 9; i++) begin
            put_bit(1'b1, r);
            allack &= r;
        end
        chk("R9 line released after NACK", int'(allack), 1);
        bus_stop(); wclk(4);

        chk("R1 sda_oe steady while SCL high", viol, 0);
        chk("R7 commit one cycle wide", commit_cyc, commit_evt);
        finish_run();
    end
endmodule